// File: doc/BRIEF.md
# Serially Programmed Divide-by-N Synthesizer Control Core

This block is the digital front end of a frequency synthesizer. A control word arrives one bit at a time on a serial clock and data pair and collects in a shift register. A separate load strobe copies that word into holding registers. The holding registers set the ratio of a programmable feedback divider and drive two general-purpose switch outputs. A three-bit select input chooses one of eight reference divide ratios from a table fixed at elaboration. A reference divider applies that ratio to reference count strobes.

The core runs on a single system clock `clk`. The serial clock, serial data and load strobe are asynchronous pins. They pass through a parameterised synchronizer chain, and the serial clock is then edge-detected. The oscillator and the feedback signal reach the block as one-cycle count strobes, `ref_tick` and `fb_tick`, made by logic outside the block. Each divider emits a one-cycle pulse once per divide period. A phase detector outside this block compares the two pulse trains.

The word is staged in two steps: shifting, then loading. New settings can therefore be shifted in while the divider and the switches keep their old values. A board that must run without a strobe can tie the load input high. The holding registers then follow the shift register continuously. A newly loaded ratio never cuts a running period short. Both dividers pick up a new ratio only when they reload.

Top module: `serial_div_synth`

## Requirements
- R1: Each rising edge of `sclk` shifts `sdata` into a word of N_W+2 bits. The first N_W bits shifted form the divide value N, most significant bit first. Bit N_W+1 of the sequence goes to `sw1`, and the last bit goes to `sw2`.
- R2: While `latch_en` is high, the holding registers follow the shift register. `sw1` and `sw2` then track the last two bits shifted, a few cycles later.
- R3: While `latch_en` is low, shifting has no effect on `sw1`, `sw2` or the feedback divide ratio.
- R4: With N of 2 or more, `fb_pulse` is high for exactly one cycle after every N `fb_tick` strobes.
- R5: An N value of 0 or 1 gives a feedback divide ratio of 3.
- R6: `ref_sel` chooses entry `ref_sel` of REF_TABLE. Entry i sits at bits [i*REF_W +: REF_W], and the defaults for codes 0 to 7 are 8, 128, 256, 512, 1024, 2048, 2410 and 8192. `ref_pulse` is high for one cycle after every that-many `ref_tick` strobes.
- R7: Neither divider advances without its strobe. A pulse only follows a cycle in which the divider's strobe was high.
- R8: A ratio loaded in the middle of a feedback period takes effect at the next reload. The period in progress completes with the old ratio.
- R9: A synchronous active-high `rst` clears the shift and holding registers, so `sw1`=`sw2`=0 and N=0. Each divider is reset to the start of a full period of its current ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock (asynchronous) |
| sdata | input | 1 | Serial data bit |
| latch_en | input | 1 | Load strobe; high copies the shift word to the holding registers |
| ref_sel | input | 3 | Reference ratio select code |
| ref_tick | input | 1 | Reference count strobe, one cycle per oscillator period |
| fb_tick | input | 1 | Feedback count strobe, one cycle per feedback period |
| ref_pulse | output | 1 | Divided reference pulse |
| fb_pulse | output | 1 | Divided feedback pulse |
| sw1 | output | 1 | Switch output from word bit N_W+1 |
| sw2 | output | 1 | Switch output from the last word bit |

## Verification
The bench builds the core with N_W=6, REF_W=4 and a small reference table of ratios 2, 3, 4, 5, 7, 10, 12 and 15. It keeps two synchronizer stages. With a 6-bit N, every one of the 64 divide values can be loaded and its period measured, including the clamped values 0 and 1. The switch bits are set to different patterns during that sweep. The narrow reference table lets all eight select codes be swept quickly, and it is also swept with a strobe on every other cycle.

// File: rtl/serial_div_synth_pkg.sv
package serial_div_synth_pkg;
   localparam int unsigned REF_CODES   = 8;
   localparam int unsigned REF_SEL_W   = $clog2(REF_CODES);
   localparam int unsigned MIN_LEGAL_N = 2;
   localparam int unsigned CLAMP_RATIO = 3;
   localparam int unsigned SW_BITS     = 2;
endpackage

// File: rtl/sds_in_sync.sv
module sds_in_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) stage[i] <= '0;
            end else begin
               stage[0] <= d;
               for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            end
         end
         assign q = stage[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sds_shift.sv
module sds_shift #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk_s,
   input  logic              sdata_s,
   output logic [WORD_W-1:0] word
);
   logic sclk_q;
   logic rise;

   assign rise = sclk_s & ~sclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_q <= 1'b0;
         word   <= '0;
      end else begin
         sclk_q <= sclk_s;
         if (rise) word <= {word[WORD_W-2:0], sdata_s};
      end
   end
endmodule

// File: rtl/sds_hold.sv
module sds_hold #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/sds_ref_table.sv
module sds_ref_table #(
   parameter int unsigned             REF_W     = 14,
   parameter int unsigned             CODES     = 8,
   parameter logic [CODES*REF_W-1:0]  TABLE     = '0
) (
   input  logic [$clog2(CODES)-1:0] sel,
   output logic [REF_W-1:0]         ratio
);
   logic [REF_W-1:0] entry [CODES];

   generate
      for (genvar i = 0; i < CODES; i++) begin : g_entry
         if (TABLE[i*REF_W +: REF_W] < 2) begin : g_bad
            $error("reference table entry below 2");
         end
         assign entry[i] = TABLE[i*REF_W +: REF_W];
      end
   endgenerate

   assign ratio = entry[sel];
endmodule

// File: rtl/sds_divider.sv
module sds_divider #(
   parameter int unsigned W = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic [W-1:0] ratio,
   output logic         pulse
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= ratio - 1'b1;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (tick) begin
            if (cnt == '0) begin
               cnt   <= ratio - 1'b1;
               pulse <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/serial_div_synth.sv
module serial_div_synth
   import serial_div_synth_pkg::*;
#(
   parameter int unsigned N_W         = 14,
   parameter int unsigned REF_W       = 14,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [REF_CODES*REF_W-1:0] REF_TABLE = {
      14'd8192, 14'd2410, 14'd2048, 14'd1024,
      14'd512,  14'd256,  14'd128,  14'd8 }
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sclk,
   input  logic                 sdata,
   input  logic                 latch_en,
   input  logic [REF_SEL_W-1:0] ref_sel,
   input  logic                 ref_tick,
   input  logic                 fb_tick,
   output logic                 ref_pulse,
   output logic                 fb_pulse,
   output logic                 sw1,
   output logic                 sw2
);
   localparam int unsigned WORD_W = N_W + SW_BITS;

   generate
      if (N_W < 2) begin : g_bad_n
         $error("N_W must be at least 2 to hold the clamp ratio");
      end
      if (REF_W < 2) begin : g_bad_ref
         $error("REF_W must be at least 2");
      end
   endgenerate

   logic [2:0]        sync_in;
   logic [2:0]        sync_out;
   logic              sclk_s, sdata_s, le_s;
   logic [WORD_W-1:0] sr_word;
   logic [WORD_W-1:0] lat_q;
   logic [N_W-1:0]    n_lat;
   logic [N_W-1:0]    n_eff;
   logic [REF_W-1:0]  ref_ratio;

   assign sync_in = {sclk, sdata, latch_en};
   assign {sclk_s, sdata_s, le_s} = sync_out;

   sds_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(sync_in), .q(sync_out));

   sds_shift #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst(rst), .sclk_s(sclk_s), .sdata_s(sdata_s), .word(sr_word));

   sds_hold #(.WORD_W(WORD_W)) u_hold (
      .clk(clk), .rst(rst), .load(le_s), .d(sr_word), .q(lat_q));

   assign n_lat = lat_q[WORD_W-1:SW_BITS];
   assign sw1   = lat_q[1];
   assign sw2   = lat_q[0];
   assign n_eff = (n_lat < N_W'(MIN_LEGAL_N)) ? N_W'(CLAMP_RATIO) : n_lat;

   sds_divider #(.W(N_W)) u_fb_div (
      .clk(clk), .rst(rst), .tick(fb_tick), .ratio(n_eff), .pulse(fb_pulse));

   sds_ref_table #(.REF_W(REF_W), .CODES(REF_CODES), .TABLE(REF_TABLE)) u_ref_tab (
      .sel(ref_sel), .ratio(ref_ratio));

   sds_divider #(.W(REF_W)) u_ref_div (
      .clk(clk), .rst(rst), .tick(ref_tick), .ratio(ref_ratio), .pulse(ref_pulse));
endmodule

// File: rtl/serial_div_synth_chk.sv
module serial_div_synth_chk #(
   parameter int unsigned WORD_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              le_s,
   input logic [WORD_W-1:0] sr_word,
   input logic [WORD_W-1:0] lat_q,
   input logic              fb_tick,
   input logic              ref_tick,
   input logic              fb_pulse,
   input logic              ref_pulse
);
   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (lat_q == '0 && sr_word == '0));

   assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
      le_s |=> lat_q == $past(sr_word));

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !le_s |=> $stable(lat_q));

   assert_fb_single_R4: assert property (@(posedge clk) disable iff (rst)
      fb_pulse |=> !fb_pulse);

   assert_fb_gated_R7: assert property (@(posedge clk) disable iff (rst)
      !fb_tick |=> !fb_pulse);

   assert_ref_gated_R7: assert property (@(posedge clk) disable iff (rst)
      !ref_tick |=> !ref_pulse);
endmodule

bind serial_div_synth serial_div_synth_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst(rst), .le_s(le_s), .sr_word(sr_word), .lat_q(lat_q),
   .fb_tick(fb_tick), .ref_tick(ref_tick), .fb_pulse(fb_pulse),
   .ref_pulse(ref_pulse));

// File: tb/serial_div_synth_tb.sv
module serial_div_synth_tb;
   localparam int unsigned N_W   = 6;
   localparam int unsigned REF_W = 4;
   localparam logic [8*REF_W-1:0] TAB = {
      4'd15, 4'd12, 4'd10, 4'd7, 4'd5, 4'd4, 4'd3, 4'd2 };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sclk = 1'b0, sdata = 1'b0, latch_en = 1'b0;
   logic [2:0] ref_sel = 3'd0;
   logic ref_tick = 1'b1, fb_tick = 1'b1;
   logic ref_pulse, fb_pulse, sw1, sw2;

   int total = 0;
   int fails = 0;

   always #4 clk = ~clk;

   serial_div_synth #(.N_W(N_W), .REF_W(REF_W), .SYNC_STAGES(2), .REF_TABLE(TAB)) u_dut (
      .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .latch_en(latch_en),
      .ref_sel(ref_sel), .ref_tick(ref_tick), .fb_tick(fb_tick),
      .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .sw1(sw1), .sw2(sw2));

   function automatic int ref_ratio(input int code);
      return int'(TAB[code*REF_W +: REF_W]);
   endfunction

   function automatic int fb_ratio(input int n);
      return (n < 2) ? 3 : n;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b);
      sdata = b;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic shift_word(input int n, input logic s1, input logic s2);
      for (int i = N_W - 1; i >= 0; i--) shift_bit(n[i]);
      shift_bit(s1);
      shift_bit(s2);
      repeat (4) @(negedge clk);
   endtask

   task automatic strobe_load();
      latch_en = 1'b1;
      repeat (6) @(negedge clk);
      latch_en = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic gap(input bit use_ref, input bit half, output int g);
      g = 0;
      do begin
         @(negedge clk);
         if (half) ref_tick = ~ref_tick;
      end while (!(use_ref ? ref_pulse : fb_pulse) && g++ < 2000);
      g = 0;
      do begin
         @(negedge clk);
         if (half) ref_tick = ~ref_tick;
         g++;
      end while (!(use_ref ? ref_pulse : fb_pulse) && g < 2000);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int g;
      int cnt;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9 reset state
      check("R9 sw1 after reset", sw1, 0);
      check("R9 sw2 after reset", sw2, 0);
      gap(1'b0, 1'b0, g);
      check("R9/R5 fb ratio after reset", g, 3);
      gap(1'b1, 1'b0, g);
      check("R9 ref ratio after reset", g, ref_ratio(0));

      // R1 R4 R5: every N value, varied switch bits
      for (int n = 0; n < (1 << N_W); n++) begin
         shift_word(n, n[0], n[1] ^ n[2]);
         strobe_load();
         check("R1 sw1", sw1, n[0]);
         check("R1 sw2", sw2, n[1] ^ n[2]);
         gap(1'b0, 1'b0, g);
         gap(1'b0, 1'b0, g);
         check(n < 2 ? "R5 clamped ratio" : "R4 fb ratio", g, fb_ratio(n));
      end

      // R3: shift without load has no effect
      shift_word(9, 1'b1, 1'b0);
      strobe_load();
      shift_word(20, 1'b0, 1'b1);
      check("R3 sw1 held", sw1, 1);
      check("R3 sw2 held", sw2, 0);
      gap(1'b0, 1'b0, g);
      gap(1'b0, 1'b0, g);
      check("R3 ratio held", g, 9);
      strobe_load();
      check("R3 sw1 after load", sw1, 0);
      check("R3 sw2 after load", sw2, 1);
      gap(1'b0, 1'b0, g);
      gap(1'b0, 1'b0, g);
      check("R3 ratio after load", g, 20);

      // R8: load mid-period; running period keeps old ratio
      shift_word(40, 1'b0, 1'b0);
      strobe_load();
      shift_word(5, 1'b0, 1'b0);
      gap(1'b0, 1'b0, g);
      g = 0;
      do begin
         @(negedge clk);
         g++;
         if (g == 3) latch_en = 1'b1;
         if (g == 9) latch_en = 1'b0;
      end while (!fb_pulse && g < 2000);
      check("R8 period spanning load", g, 40);
      gap(1'b0, 1'b0, g);
      check("R8 next period", g, 5);

      // R7: no feedback strobe, no pulse
      fb_tick = 1'b0;
      cnt = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (fb_pulse) cnt++;
      end
      check("R7 no fb pulse without strobe", cnt, 0);
      fb_tick = 1'b1;

      // R2: transparent while load held high
      latch_en = 1'b1;
      shift_bit(1'b1);
      repeat (6) @(negedge clk);
      check("R2 sw2 tracks", sw2, 1);
      shift_bit(1'b0);
      repeat (6) @(negedge clk);
      check("R2 sw1 tracks", sw1, 1);
      check("R2 sw2 tracks", sw2, 0);
      latch_en = 1'b0;

      // R6: all reference codes, full rate and half rate (R7)
      for (int c = 0; c < 8; c++) begin
         ref_sel = 3'(c);
         ref_tick = 1'b1;
         gap(1'b1, 1'b0, g);
         gap(1'b1, 1'b0, g);
         check("R6 ref ratio", g, ref_ratio(c));
         gap(1'b1, 1'b1, g);
         gap(1'b1, 1'b1, g);
         check("R7 ref half-rate", g, 2 * ref_ratio(c));
      end
      ref_tick = 1'b1;

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule